// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Counter

This block is a synchronous binary up-counter made of 4-bit stages. A parameter sets the number of stages, so the counter is `4 * NUM_STAGES` bits wide. All stages share one clock. On each rising edge a stage does one of four things, in fixed priority: it clears to zero, it takes the value on its data inputs, it adds one, or it holds.

Counting needs two enables. `cnt_en_i` goes to every stage in common and only gates counting. `chain_en_i` gates both counting and the carry. Each stage's carry is its `chain_en` ANDed with all four of its bits. That carry drives the `chain_en` of the next stage, so the stages form a synchronous lookahead chain. The last carry leaves the block on `carry_o`, and a wider counter can be built by feeding it into the `chain_en_i` of another instance.

Clear and load are active low and act on every stage at once. An active-low asynchronous reset `rst_ni` puts the counter in a known state at power-up.

Top module: `cascade_counter`

## Requirements
- R1: When `clr_ni` is low at a rising edge, `count_o` becomes zero on that edge, whatever the levels of load, the enables and the data.
- R2: When `clr_ni` is high and `load_ni` is low at a rising edge, `count_o` takes the value of `data_i` on that edge, whatever the enable levels.
- R3: When `clr_ni`, `load_ni`, `cnt_en_i` and `chain_en_i` are all high at a rising edge, `count_o` increases by one.
- R4: When `clr_ni` and `load_ni` are high and either `cnt_en_i` or `chain_en_i` is low, `count_o` keeps its value across the edge.
- R5: A stage's carry is high exactly when its `chain_en` is high and its four bits are all ones. `cnt_en_i` has no effect on any carry.
- R6: Stage k (bits 4k+3..4k) advances only when every lower stage reads fifteen. The full-width counter wraps from all ones to zero.
- R7: `carry_o` is high exactly when `count_o` is all ones and `chain_en_i` is high.
- R8: While `rst_ni` is low, `count_o` is zero, independent of the clock.
- R9: The counter steps through this sequence with the low stage running 12, 13, 14, 15, 0, 1, 2, then holds once the enables are dropped. The run starts from a clear, loads 0xFC, and counts with the upper stage carrying from 0xF to 0x0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock shared by all stages |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_ni | input | 1 | Synchronous clear, active low, highest priority |
| load_ni | input | 1 | Synchronous parallel load, active low |
| cnt_en_i | input | 1 | Common count enable; does not touch the carry |
| chain_en_i | input | 1 | Count enable of the first stage; also gates the carry chain |
| data_i | input | 4*NUM_STAGES | Parallel load value |
| count_o | output | 4*NUM_STAGES | Counter value |
| carry_o | output | 1 | Carry out of the last stage |

## Verification
Several directed patterns each test one part of the behaviour:
- Clear and load are asserted together with both enables. This shows that the priority is clear, then load, then count.
- Each enable is dropped alone. This separates the enable that only holds the count from the enable that also kills the carry.
- The count is loaded at values just below a nibble boundary (0x0E, 0x0F) and at all ones. This shows whether the carry ripples into the next stage at the right count and whether the full counter wraps.
- A long random run applies clear, load, enable and data patterns, including collisions. Each cycle is compared against an integer model, which catches any ordering or carry-gating slip the directed cases missed.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  localparam int unsigned NIB_W = 4;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_INC   = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } stage_op_e;
endpackage

// File: rtl/cnt_stage_op.sv
module cnt_stage_op
  import cnt_pkg::*;
(
  input  logic      clr_ni,
  input  logic      load_ni,
  input  logic      cnt_en_i,
  input  logic      chain_en_i,
  output stage_op_e op_o
);
  // fixed priority: clear > load > count > hold
  always_comb begin
    if (!clr_ni)                      op_o = OP_CLEAR;
    else if (!load_ni)                op_o = OP_LOAD;
    else if (cnt_en_i && chain_en_i)  op_o = OP_INC;
    else                              op_o = OP_HOLD;
  end
endmodule

// File: rtl/cnt_stage.sv
module cnt_stage
  import cnt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_ni,
  input  logic             load_ni,
  input  logic             cnt_en_i,
  input  logic             chain_en_i,
  input  logic [NIB_W-1:0] data_i,
  output logic [NIB_W-1:0] q_o,
  output logic             carry_o
);
  stage_op_e op;

  cnt_stage_op u_op (
    .clr_ni     (clr_ni),
    .load_ni    (load_ni),
    .cnt_en_i   (cnt_en_i),
    .chain_en_i (chain_en_i),
    .op_o       (op)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else begin
      case (op)
        OP_CLEAR: q_o <= '0;
        OP_LOAD:  q_o <= data_i;
        OP_INC:   q_o <= q_o + NIB_W'(1);
        default:  q_o <= q_o;
      endcase
    end
  end

  // lookahead carry: enable P deliberately absent
  assign carry_o = chain_en_i & (&q_o);

  assert_clear_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |=> q_o == '0);
  assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_ni && !load_ni |=> q_o == $past(data_i));
  assert_count_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_ni && load_ni && cnt_en_i && chain_en_i |=> q_o == $past(q_o) + NIB_W'(1));
  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_ni && load_ni && !(cnt_en_i && chain_en_i) |=> $stable(q_o));
  assert_carry_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o |-> chain_en_i && q_o == '1);
endmodule

// File: rtl/cascade_counter.sv
module cascade_counter
  import cnt_pkg::*;
#(
  parameter int unsigned NUM_STAGES = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        clr_ni,
  input  logic                        load_ni,
  input  logic                        cnt_en_i,
  input  logic                        chain_en_i,
  input  logic [NUM_STAGES*NIB_W-1:0] data_i,
  output logic [NUM_STAGES*NIB_W-1:0] count_o,
  output logic                        carry_o
);
  localparam int unsigned CNT_W = NUM_STAGES * NIB_W;

  logic [NUM_STAGES:0] chain;
  assign chain[0] = chain_en_i;

  for (genvar k = 0; k < NUM_STAGES; k++) begin : g_stage
    cnt_stage u_stage (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clr_ni     (clr_ni),
      .load_ni    (load_ni),
      .cnt_en_i   (cnt_en_i),
      .chain_en_i (chain[k]),
      .data_i     (data_i[k*NIB_W +: NIB_W]),
      .q_o        (count_o[k*NIB_W +: NIB_W]),
      .carry_o    (chain[k+1])
    );
  end

  assign carry_o = chain[NUM_STAGES];

  assert_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_ni && load_ni && cnt_en_i && chain_en_i && count_o == {CNT_W{1'b1}}
    |=> count_o == '0);
  assert_full_carry_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o == {CNT_W{1'b1}} && chain_en_i) |-> carry_o);
  assert_reset_R8: assert property (@(posedge clk_i)
    !rst_ni |-> count_o == '0);
endmodule

// File: tb/cascade_counter_tb_top.sv
module cascade_counter_tb_top;
  localparam int unsigned N = 2;
  localparam int unsigned W = 4 * N;

  logic clk_i = 1'b0;
  logic rst_ni, clr_ni, load_ni, cnt_en_i, chain_en_i;
  logic [W-1:0] data_i, count_o;
  logic carry_o;
  logic [W-1:0] model;
  int checks = 0;
  int fails = 0;

  always #5ns clk_i = ~clk_i;

  cascade_counter #(.NUM_STAGES(N)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_ni(clr_ni), .load_ni(load_ni),
    .cnt_en_i(cnt_en_i), .chain_en_i(chain_en_i), .data_i(data_i),
    .count_o(count_o), .carry_o(carry_o)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic l, input logic p, input logic t, input logic [W-1:0] d);
    clr_ni = c; load_ni = l; cnt_en_i = p; chain_en_i = t; data_i = d;
  endtask

  // model step, clock edge, then compare count and carry
  task automatic tick(input string req);
    if (!clr_ni) model = '0;
    else if (!load_ni) model = data_i;
    else if (cnt_en_i && chain_en_i) model = model + W'(1);
    @(posedge clk_i); #1;
    check(req, count_o, model);
    check({req, " carry"}, W'(carry_o), W'(chain_en_i && model == {W{1'b1}}));
  endtask

  task automatic t_reset;
    rst_ni = 1'b0; drive(1, 1, 1, 1, '0); model = '0;
    #12;
    check("R8", count_o, '0);
    @(posedge clk_i); #1;
    check("R8", count_o, '0);
    rst_ni = 1'b1;
  endtask

  task automatic t_sequence;
    drive(0, 1, 1, 1, '0); tick("R9 clear");
    drive(1, 0, 0, 0, 8'hFC); tick("R9 load");
    drive(1, 1, 1, 1, '0);
    for (int i = 0; i < 6; i++) tick("R9 count");
    check("R9 final", count_o, 8'h02);
    drive(1, 1, 0, 0, '0); tick("R9 hold"); tick("R9 hold");
    check("R9 held", count_o, 8'h02);
  endtask

  task automatic t_priority;
    drive(1, 0, 1, 1, 8'h5A); tick("R2 load");
    drive(0, 0, 1, 1, 8'hA5); tick("R1 clear over load");
    drive(1, 0, 1, 1, 8'h3C); tick("R2 load over count");
    check("R2", count_o, 8'h3C);
    drive(1, 1, 1, 1, 8'hFF); tick("R3 count");
    check("R3", count_o, 8'h3D);
  endtask

  task automatic t_enables;
    drive(1, 1, 0, 1, '0); tick("R4 cnt_en low");
    check("R4", count_o, 8'h3D);
    drive(1, 1, 1, 0, '0); tick("R4 chain_en low");
    check("R4", count_o, 8'h3D);
  endtask

  task automatic t_carry;
    drive(1, 0, 0, 0, 8'h0E); tick("R6 load");
    drive(1, 1, 1, 1, '0); tick("R6 low nibble only");
    check("R6 upper still", count_o, 8'h0F);
    tick("R6 carry into upper");
    check("R6", count_o, 8'h10);
    drive(1, 0, 0, 0, 8'hFF); tick("R7 load ones");
    drive(1, 1, 0, 1, '0); #1;
    check("R5 cnt_en no effect", W'(carry_o), W'(1));
    drive(1, 1, 1, 0, '0); #1;
    check("R7 chain_en gates", W'(carry_o), W'(0));
    drive(1, 1, 1, 1, '0); #1;
    check("R7 carry", W'(carry_o), W'(1));
    tick("R6 wrap");
    check("R6 wrap", count_o, 8'h00);
  endtask

  task automatic t_random;
    for (int i = 0; i < 400; i++) begin
      logic [3:0] r;
      r = 4'($urandom);
      drive(($urandom % 8) != 0, ($urandom % 6) != 0, r[0] | r[1], r[2] | r[3],
            W'($urandom));
      if ((i % 50) == 0) drive(1, 0, 1, 1, 8'hFD);
      tick("R3 random");
    end
  endtask

  initial begin
    t_reset;
    t_sequence;
    t_priority;
    t_enables;
    t_carry;
    t_random;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100us;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule